// File: doc/BRIEF.md
# Instruction Fetch Handshake Monitor

This block sits next to an instruction-fetch unit, such as a cache or a prefetcher, and watches the handshake between that unit and the core. It is synthesizable, so the same checks can run in simulation, in emulation or in silicon. Each cycle it looks at these signals:

- the branch request and its target address;
- the fetch valid flag and the core ready flag;
- the fetch address and the 32-bit fetch data;
- the error flag and the plus-two error flag.

From these it keeps two pieces of state. The first is whether a fetch transaction is still open. The second is whether the fetch unit holds a known architectural address.

Each protocol rule has its own sticky violation bit, and only reset clears it. The stability rules are aware of 16-bit parcels. The upper half of the data only has to hold when the lower half encodes a full-length 32-bit instruction. The plus-two error flag is tied to instruction length. A flag rises in the cycle after the offending input cycle. An integrator can route the flags to a debug register or an interrupt.

Top module: `fetch_proto_monitor`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, every violation bit, `pending_o` and `addr_known_o` read 0.
- R2: `addr_known_o` becomes 1 the cycle after `branch_i` is high. It becomes 0 the cycle after a cycle where `valid_i`, `ready_i` and `err_i` are high and `branch_i` is low. Otherwise it holds.
- R3: `pending_o` is 1 in a cycle when the previous cycle had `valid_i`=1, `ready_i`=0 and `branch_i`=0. A transaction is pending in a cycle when `pending_o`=1 and `branch_i`=0. Dropping `valid_i` while pending sets violation bit 0.
- R4: A change of `addr_i` versus the previous cycle while pending sets bit 1.
- R5: A change of `err_i` versus the previous cycle while pending sets bit 2.
- R6: `valid_i`=1, `branch_i`=0, `err_plus2_i`=1 and `err_i`=0 together set bit 3.
- R7: `valid_i`=1, `branch_i`=0, `err_i`=1 and `err_plus2_i`=1, with `rdata_i[1:0]` not equal to 2'b11, set bit 4. A 16-bit parcel is uncompressed when its bits [1:0] are 2'b11.
- R8: While pending with `err_i`=0, a change of `rdata_i[15:0]` sets bit 5.
- R9: While pending with `err_i`=0, if the previous cycle's `rdata_i[1:0]` was 2'b11, a change of `rdata_i[31:16]` sets bit 6. If it was not 2'b11, upper-half changes are ignored.
- R10: `branch_i`=1 with `branch_addr_i[0]`=1 sets bit 7. This rule is checked even when no address is known.
- R11: With `GATE_ON_KNOWN`=1, rules R3 to R9 record nothing in cycles where `addr_known_o` is 0.
- R12: A violation bit stays set until reset. `any_violation_o` is the OR of all eight bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| branch_i | input | 1 | Core requests a fetch redirect |
| branch_addr_i | input | ADDR_W | Redirect target address |
| valid_i | input | 1 | Fetch unit presents an instruction |
| ready_i | input | 1 | Core accepts the instruction |
| addr_i | input | ADDR_W | Address of the presented instruction |
| rdata_i | input | DATA_W | Presented instruction data |
| err_i | input | 1 | Fetch error |
| err_plus2_i | input | 1 | Error lies in the second parcel |
| violations_o | output | 8 | Sticky per-rule violation bits |
| any_violation_o | output | 1 | OR of all violation bits |
| pending_o | output | 1 | Previous cycle left a transaction open |
| addr_known_o | output | 1 | Architectural address is known |

## Verification
The bench builds the monitor with its defaults: 32-bit address, 32-bit data and gating on the known-address state. With these values both 16-bit halves of the data exist, so the half-aware rules R8 and R9 and the length tie of R7 can all be exercised. The gating also lets directed cases show that rule breaks made before any redirect are ignored, while a misaligned redirect is still flagged. Random traffic mostly keeps the protocol and injects single faults, with periodic resets that clear the sticky bits. A bench model predicts every output bit in every cycle.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

   localparam int unsigned NUM_RULES = 8;

   typedef enum int unsigned {
      RULE_VALID_DROP  = 0,
      RULE_ADDR_MOVE   = 1,
      RULE_ERR_MOVE    = 2,
      RULE_P2_NO_ERR   = 3,
      RULE_P2_LENGTH   = 4,
      RULE_LO_MOVE     = 5,
      RULE_HI_MOVE     = 6,
      RULE_MISALIGNED  = 7
   } rule_e;

   localparam logic [1:0] FULL_LEN_CODE = 2'b11;

endpackage

// File: rtl/fpm_track.sv
module fpm_track #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              branch_i,
   input  logic              valid_i,
   input  logic              ready_i,
   input  logic              err_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] rdata_i,
   output logic              pend_q_o,
   output logic              known_q_o,
   output logic [ADDR_W-1:0] addr_q_o,
   output logic [DATA_W-1:0] data_q_o,
   output logic              err_q_o
);

   logic pend_d;
   logic known_d;
   logic done_with_err;

   assign pend_d        = valid_i & ~ready_i & ~branch_i;
   assign done_with_err = valid_i & ready_i & err_i & ~branch_i;

   always_comb begin
      known_d = known_q_o;
      if (branch_i) begin
         known_d = 1'b1;
      end else if (done_with_err) begin
         known_d = 1'b0;
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         pend_q_o  <= 1'b0;
         known_q_o <= 1'b0;
      end else begin
         pend_q_o  <= pend_d;
         known_q_o <= known_d;
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         addr_q_o <= '0;
         data_q_o <= '0;
         err_q_o  <= 1'b0;
      end else begin
         addr_q_o <= addr_i;
         data_q_o <= rdata_i;
         err_q_o  <= err_i;
      end
   end

endmodule

// File: rtl/fpm_rules.sv
module fpm_rules
   import fpm_pkg::*;
#(
   parameter int unsigned ADDR_W        = 32,
   parameter int unsigned DATA_W        = 32,
   parameter bit          GATE_ON_KNOWN = 1'b1
) (
   input  logic                 pend_q_i,
   input  logic                 known_q_i,
   input  logic [ADDR_W-1:0]    addr_q_i,
   input  logic [DATA_W-1:0]    data_q_i,
   input  logic                 err_q_i,
   input  logic                 branch_i,
   input  logic                 branch_lsb_i,
   input  logic                 valid_i,
   input  logic [ADDR_W-1:0]    addr_i,
   input  logic [DATA_W-1:0]    rdata_i,
   input  logic                 err_i,
   input  logic                 err_plus2_i,
   output logic [NUM_RULES-1:0] hit_o
);

   localparam int unsigned HALF_W = DATA_W / 2;

   logic                 open_now;
   logic                 shown;
   logic                 prev_full_len;
   logic                 cur_full_len;
   logic                 gate;
   logic [NUM_RULES-1:0] raw;

   assign open_now      = pend_q_i & ~branch_i;
   assign shown         = valid_i & ~branch_i;
   assign prev_full_len = (data_q_i[1:0] == FULL_LEN_CODE);
   assign cur_full_len  = (rdata_i[1:0] == FULL_LEN_CODE);

   always_comb begin
      raw = '0;
      raw[RULE_VALID_DROP] = open_now & ~valid_i;
      raw[RULE_ADDR_MOVE]  = open_now & (addr_i != addr_q_i);
      raw[RULE_ERR_MOVE]   = open_now & (err_i != err_q_i);
      raw[RULE_P2_NO_ERR]  = shown & err_plus2_i & ~err_i;
      raw[RULE_P2_LENGTH]  = shown & err_plus2_i & err_i & ~cur_full_len;
      raw[RULE_LO_MOVE]    = open_now & ~err_i &
                             (rdata_i[HALF_W-1:0] != data_q_i[HALF_W-1:0]);
      raw[RULE_HI_MOVE]    = open_now & ~err_i & prev_full_len &
                             (rdata_i[DATA_W-1:HALF_W] != data_q_i[DATA_W-1:HALF_W]);
      raw[RULE_MISALIGNED] = branch_i & branch_lsb_i;
   end

   generate
      if (GATE_ON_KNOWN) begin : g_gated
         assign gate = known_q_i;
      end else begin : g_ungated
         logic unused_known;
         assign unused_known = known_q_i;
         assign gate = 1'b1;
      end
   endgenerate

   always_comb begin
      hit_o = raw & {NUM_RULES{gate}};
      hit_o[RULE_MISALIGNED] = raw[RULE_MISALIGNED];
   end

endmodule

// File: rtl/fpm_sticky.sv
module fpm_sticky #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] set_i,
   output logic [WIDTH-1:0] flag_q_o
);

   for (genvar k = 0; k < WIDTH; k++) begin : g_bit
      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            flag_q_o[k] <= 1'b0;
         end else if (set_i[k]) begin
            flag_q_o[k] <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/fetch_proto_monitor.sv
module fetch_proto_monitor
   import fpm_pkg::*;
#(
   parameter int unsigned ADDR_W        = 32,
   parameter int unsigned DATA_W        = 32,
   parameter bit          GATE_ON_KNOWN = 1'b1
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 branch_i,
   input  logic [ADDR_W-1:0]    branch_addr_i,
   input  logic                 valid_i,
   input  logic                 ready_i,
   input  logic [ADDR_W-1:0]    addr_i,
   input  logic [DATA_W-1:0]    rdata_i,
   input  logic                 err_i,
   input  logic                 err_plus2_i,
   output logic [NUM_RULES-1:0] violations_o,
   output logic                 any_violation_o,
   output logic                 pending_o,
   output logic                 addr_known_o
);

   generate
      if (DATA_W != 32) begin : g_bad_data_w
         $error("fetch_proto_monitor: DATA_W must be 32");
      end
      if (ADDR_W < 2) begin : g_bad_addr_w
         $error("fetch_proto_monitor: ADDR_W must be at least 2");
      end
   endgenerate

   logic                 pend_q;
   logic                 known_q;
   logic [ADDR_W-1:0]    addr_q;
   logic [DATA_W-1:0]    data_q;
   logic                 err_q;
   logic [NUM_RULES-1:0] hits;
   logic                 unused_branch_hi;

   assign unused_branch_hi = ^branch_addr_i[ADDR_W-1:1];

   fpm_track #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_track (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .branch_i  (branch_i),
      .valid_i   (valid_i),
      .ready_i   (ready_i),
      .err_i     (err_i),
      .addr_i    (addr_i),
      .rdata_i   (rdata_i),
      .pend_q_o  (pend_q),
      .known_q_o (known_q),
      .addr_q_o  (addr_q),
      .data_q_o  (data_q),
      .err_q_o   (err_q)
   );

   fpm_rules #(
      .ADDR_W        (ADDR_W),
      .DATA_W        (DATA_W),
      .GATE_ON_KNOWN (GATE_ON_KNOWN)
   ) u_rules (
      .pend_q_i     (pend_q),
      .known_q_i    (known_q),
      .addr_q_i     (addr_q),
      .data_q_i     (data_q),
      .err_q_i      (err_q),
      .branch_i     (branch_i),
      .branch_lsb_i (branch_addr_i[0]),
      .valid_i      (valid_i),
      .addr_i       (addr_i),
      .rdata_i      (rdata_i),
      .err_i        (err_i),
      .err_plus2_i  (err_plus2_i),
      .hit_o        (hits)
   );

   fpm_sticky #(
      .WIDTH (NUM_RULES)
   ) u_sticky (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_i    (hits),
      .flag_q_o (violations_o)
   );

   assign any_violation_o = |violations_o;
   assign pending_o       = pend_q;
   assign addr_known_o    = known_q;

endmodule

// File: rtl/fpm_checker.sv
module fpm_checker
   import fpm_pkg::*;
#(
   parameter int unsigned ADDR_W        = 32,
   parameter bit          GATE_ON_KNOWN = 1'b1
) (
   input logic                 clk_i,
   input logic                 rst_ni,
   input logic                 branch_i,
   input logic [ADDR_W-1:0]    branch_addr_i,
   input logic                 valid_i,
   input logic                 ready_i,
   input logic [ADDR_W-1:0]    addr_i,
   input logic                 err_i,
   input logic [NUM_RULES-1:0] violations_o,
   input logic                 pending_o,
   input logic                 addr_known_o
);

   logic armed;
   assign armed = addr_known_o | ~GATE_ON_KNOWN;

   assert_reset_clear_R1: assert property (@(posedge clk_i)
      !rst_ni |=> (violations_o == '0) && !pending_o && !addr_known_o);

   assert_known_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      branch_i |=> addr_known_o);

   assert_known_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i && ready_i && err_i && !branch_i |=> !addr_known_o);

   assert_valid_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed && pending_o && !branch_i && !valid_i |=> violations_o[RULE_VALID_DROP]);

   assert_addr_move_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed && pending_o && !branch_i && (addr_i != $past(addr_i))
      |=> violations_o[RULE_ADDR_MOVE]);

   assert_misaligned_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      branch_i && branch_addr_i[0] |=> violations_o[RULE_MISALIGNED]);

   assert_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      violations_o != '0 |=> (violations_o & $past(violations_o)) == $past(violations_o));

endmodule

bind fetch_proto_monitor fpm_checker #(
   .ADDR_W        (ADDR_W),
   .GATE_ON_KNOWN (GATE_ON_KNOWN)
) u_fpm_checker (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .branch_i      (branch_i),
   .branch_addr_i (branch_addr_i),
   .valid_i       (valid_i),
   .ready_i       (ready_i),
   .addr_i        (addr_i),
   .err_i         (err_i),
   .violations_o  (violations_o),
   .pending_o     (pending_o),
   .addr_known_o  (addr_known_o)
);

// File: tb/fetch_proto_monitor_tb.sv
module fetch_proto_monitor_tb;

   localparam int AW = 32;
   localparam int DW = 32;
   localparam int NR = 8;

   logic          clk = 1'b0;
   logic          rst_ni = 1'b0;
   logic          branch_i = 1'b0;
   logic [AW-1:0] branch_addr_i = '0;
   logic          valid_i = 1'b0;
   logic          ready_i = 1'b0;
   logic [AW-1:0] addr_i = '0;
   logic [DW-1:0] rdata_i = '0;
   logic          err_i = 1'b0;
   logic          err_plus2_i = 1'b0;
   logic [NR-1:0] violations_o;
   logic          any_violation_o;
   logic          pending_o;
   logic          addr_known_o;

   always #2 clk = ~clk;

   fetch_proto_monitor u_dut (
      .clk_i           (clk),
      .rst_ni          (rst_ni),
      .branch_i        (branch_i),
      .branch_addr_i   (branch_addr_i),
      .valid_i         (valid_i),
      .ready_i         (ready_i),
      .addr_i          (addr_i),
      .rdata_i         (rdata_i),
      .err_i           (err_i),
      .err_plus2_i     (err_plus2_i),
      .violations_o    (violations_o),
      .any_violation_o (any_violation_o),
      .pending_o       (pending_o),
      .addr_known_o    (addr_known_o)
   );

   int checks = 0;
   int fails = 0;
   bit finished = 1'b0;

   // reference model state
   logic          m_pend, m_known, m_perr;
   logic [AW-1:0] m_paddr;
   logic [DW-1:0] m_pdata;
   logic [NR-1:0] m_flags;

   function automatic string rule_tag(int k);
      case (k)
         0: return "R3";
         1: return "R4";
         2: return "R5";
         3: return "R6";
         4: return "R7";
         5: return "R8";
         6: return "R9";
         default: return "R10";
      endcase
   endfunction

   task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [NR-1:0] model_hits(logic b, logic [AW-1:0] ba, logic v,
                                                logic [AW-1:0] a, logic [DW-1:0] d,
                                                logic e, logic p2);
      logic [NR-1:0] h;
      logic open_now;
      open_now = m_pend && !b;
      h[0] = open_now && !v;
      h[1] = open_now && (a != m_paddr);
      h[2] = open_now && (e != m_perr);
      h[3] = v && !b && p2 && !e;
      h[4] = v && !b && p2 && e && (d[1:0] != 2'b11);
      h[5] = open_now && !e && (d[15:0] != m_pdata[15:0]);
      h[6] = open_now && !e && (m_pdata[1:0] == 2'b11) && (d[31:16] != m_pdata[31:16]);
      if (!m_known) h[6:0] = '0; // R11 gating
      h[7] = b && ba[0];
      return h;
   endfunction

   task automatic model_step();
      m_flags = m_flags | model_hits(branch_i, branch_addr_i, valid_i, addr_i,
                                     rdata_i, err_i, err_plus2_i);
      if (branch_i) m_known = 1'b1;
      else if (valid_i && ready_i && err_i) m_known = 1'b0;
      m_pend  = valid_i && !ready_i && !branch_i;
      m_paddr = addr_i;
      m_pdata = rdata_i;
      m_perr  = err_i;
   endtask

   task automatic compare_all();
      for (int k = 0; k < NR; k++) begin
         check(violations_o[k] === m_flags[k], rule_tag(k), 64'(violations_o[k]),
               64'(m_flags[k]));
      end
      check(addr_known_o === m_known, "R2", 64'(addr_known_o), 64'(m_known));
      check(pending_o === m_pend, "R3", 64'(pending_o), 64'(m_pend));
      check(any_violation_o === (|m_flags), "R12", 64'(any_violation_o), 64'(|m_flags));
   endtask

   task automatic step(logic b, logic [AW-1:0] ba, logic v, logic r,
                       logic [AW-1:0] a, logic [DW-1:0] d, logic e, logic p2);
      branch_i = b; branch_addr_i = ba; valid_i = v; ready_i = r;
      addr_i = a; rdata_i = d; err_i = e; err_plus2_i = p2;
      model_step();
      @(negedge clk);
      compare_all();
   endtask

   task automatic do_reset();
      rst_ni = 1'b0;
      branch_i = 0; branch_addr_i = '0; valid_i = 0; ready_i = 0;
      addr_i = '0; rdata_i = '0; err_i = 0; err_plus2_i = 0;
      @(negedge clk);
      @(negedge clk);
      m_pend = 0; m_known = 0; m_perr = 0; m_paddr = '0; m_pdata = '0; m_flags = '0;
      check(violations_o === '0, "R1", 64'(violations_o), 64'd0);
      check(!pending_o && !addr_known_o, "R1", {pending_o, addr_known_o}, 64'd0);
      rst_ni = 1'b1;
      @(negedge clk);
      compare_all();
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      #(4 * 150000);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic          g_v, g_e, g_p2, b, r, iv, ie, ip2;
      logic [AW-1:0] g_a, ba, ia;
      logic [DW-1:0] g_d, id;
      void'($urandom(32'd20240611));
      @(negedge clk);
      do_reset();

      // R11: rule breaks before any redirect are ignored
      step(0, 0, 1, 0, 32'h100, 32'h0000_0013, 0, 0);
      step(0, 0, 0, 0, 32'h104, 32'h0000_0000, 0, 0);
      check(violations_o === '0, "R11", 64'(violations_o), 64'd0);

      // R10: misaligned redirect flagged even while unknown; R2 sets known
      step(1, 32'h201, 0, 0, 0, 0, 0, 0);
      check(violations_o[7] === 1'b1, "R10", 64'(violations_o[7]), 64'd1);
      check(addr_known_o === 1'b1, "R2", 64'(addr_known_o), 64'd1);

      // R9 ignored case: compressed low half, upper half moves
      do_reset();
      step(1, 32'h400, 0, 0, 0, 0, 0, 0);
      step(0, 0, 1, 0, 32'h400, 32'hAAAA_0001, 0, 0);
      step(0, 0, 1, 1, 32'h400, 32'h5555_0001, 0, 0);
      check(violations_o[6] === 1'b0, "R9", 64'(violations_o[6]), 64'd0);
      // R9: full-length low half, upper half moves
      step(0, 0, 1, 0, 32'h404, 32'hAAAA_0003, 0, 0);
      step(0, 0, 1, 1, 32'h404, 32'h5555_0003, 0, 0);
      check(violations_o[6] === 1'b1, "R9", 64'(violations_o[6]), 64'd1);
      // R7 then R2: errored completion with short parcel, address forgotten
      step(0, 0, 1, 1, 32'h408, 32'h0000_0000, 1, 1);
      check(violations_o[4] === 1'b1, "R7", 64'(violations_o[4]), 64'd1);
      check(addr_known_o === 1'b0, "R2", 64'(addr_known_o), 64'd0);
      // R12: flags stay set across idle cycles
      step(0, 0, 0, 0, 0, 0, 0, 0);
      check(violations_o[6] && violations_o[4], "R12", 64'(violations_o), 64'h50);

      // random traffic with injected faults
      for (int blk = 0; blk < 20; blk++) begin
         do_reset();
         g_v = 0; g_a = '0; g_d = '0; g_e = 0; g_p2 = 0;
         for (int c = 0; c < 300; c++) begin
            b  = ($urandom % 10) == 0;
            ba = $urandom & ~32'h1;
            if (($urandom % 40) == 0) ba[0] = 1'b1;
            if (!(m_pend && !b)) begin
               g_v  = ($urandom % 4) != 0;
               g_a  = $urandom & ~32'h1;
               g_d  = $urandom;
               g_e  = ($urandom % 6) == 0;
               g_p2 = g_e && ($urandom % 2);
               if (g_p2) g_d[1:0] = 2'b11;
               if (($urandom % 2) == 0) g_d[1:0] = 2'b11;
            end
            r = ($urandom % 3) == 0;
            iv = g_v; ia = g_a; id = g_d; ie = g_e; ip2 = g_p2;
            if (($urandom % 25) == 0) begin
               case ($urandom % 6)
                  0: iv = ~iv;
                  1: ia[2] = ~ia[2];
                  2: ie = ~ie;
                  3: ip2 = 1'b1;
                  4: id[5] = ~id[5];
                  default: id[20] = ~id[20];
               endcase
            end
            step(b, ba, iv, r, ia, id, ie, ip2);
         end
      end
      finish_run();
   end

endmodule